// File: doc/BRIEF.md
# Two-Level Shared Interrupt Request Logic

This block gathers a small group of peripheral interrupt sources under one shared group-level request flag. It produces a single vector-jump request to the CPU. Each source has its own request flag, and an event from that source sets it. The same event also sets the shared group flag. Both flags are set whether or not any enable is on, so software can poll them with interrupts masked.

A vector request is raised only when all of the following hold:
- the global enable is on;
- the group enable is on;
- the group flag is set;
- at least one source has both its own flag and its own enable set;
- the call stack is not full.

Once raised, the request is held as a level until the CPU acknowledges it. On acknowledge, hardware clears the group flag only. Each source flag stays set until software clears it. This lets the service routine find out which source raised the interrupt.

Top module: `irq_shared_top`

## Requirements
- R1: An event pulse on source i sets that source's flag at the next clock edge, whatever the enable bits are.
- R2: An event on any source sets the group flag at the next clock edge, whatever the enable bits are.
- R3: A software clear of source i clears its flag at the next edge; if an event on the same source arrives in the same cycle, the flag ends up set.
- R4: A software clear of the group flag clears it at the next edge; if any source event arrives in the same cycle, the group flag ends up set.
- R5: The vector request rises one edge after a cycle in which global enable, group enable and the group flag are all 1, some source has flag and enable both 1, and stack-full is 0.
- R6: While stack-full is 1, no new vector request is raised even when every enable and flag is set.
- R7: Once raised, the vector request stays 1 until acknowledge, even if the enables drop or stack-full rises.
- R8: Acknowledge clears the vector request and the group flag at the next edge; a source event in the same cycle keeps the group flag set.
- R9: Acknowledge never clears any source flag.
- R10: After reset, all source flags, the group flag and the vector request are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | N_SRC | Per-source event pulses |
| src_en_i | input | N_SRC | Per-source interrupt enables |
| grp_en_i | input | 1 | Group enable |
| glb_en_i | input | 1 | Global interrupt enable |
| stack_full_i | input | 1 | Call stack is full |
| ack_i | input | 1 | Interrupt acknowledge strobe from the CPU |
| src_clr_i | input | N_SRC | Software clear, one per source flag |
| grp_clr_i | input | 1 | Software clear of the group flag |
| src_flag_o | output | N_SRC | Per-source request flags |
| grp_flag_o | output | 1 | Group-level request flag |
| vec_req_o | output | 1 | Vector-jump request to the CPU |

## Verification
The assertions assume that acknowledge arrives only while the vector request is high. This matches a CPU that acknowledges only the vector it was asked to take. The stimulus honours this: it raises acknowledge only in cycles where its own model shows a pending request. Events and clears are otherwise driven freely. This includes the same-cycle collisions of an event with a software clear, or with an acknowledge, which are the corner cases of the set-wins rule. The bench also drives stack-full high while every enable is on, and drops the enables while a request is pending.

// File: rtl/irq_shared_pkg.sv
package irq_shared_pkg;

    typedef struct packed {
        logic flag;
    } flag_state_t;

    typedef struct packed {
        logic req;
    } gate_state_t;

endpackage

// File: rtl/irq_src_flag.sv
module irq_src_flag
    import irq_shared_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic flag_o,
    output logic armed_o
);

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.flag = 1'b0;
        end
        if (set_i) begin
            st_d.flag = 1'b1;      // set has priority over clear
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o  = st_q.flag;
    assign armed_o = st_q.flag & en_i;

endmodule

// File: rtl/irq_grp_flag.sv
module irq_grp_flag
    import irq_shared_pkg::*;
#(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             sw_clr_i,
    input  logic             ack_i,
    output logic             flag_o
);

    flag_state_t st_d, st_q;
    logic        any_evt;

    always_comb begin
        any_evt = |evt_i;
        st_d    = st_q;
        if (sw_clr_i || ack_i) begin
            st_d.flag = 1'b0;
        end
        if (any_evt) begin
            st_d.flag = 1'b1;      // a new event outranks both clears
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/irq_vec_gate.sv
module irq_vec_gate
    import irq_shared_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic glb_en_i,
    input  logic grp_en_i,
    input  logic grp_flag_i,
    input  logic any_armed_i,
    input  logic stack_full_i,
    input  logic ack_i,
    output logic req_o
);

    gate_state_t st_d, st_q;
    logic        take;

    always_comb begin
        take = glb_en_i & grp_en_i & grp_flag_i & any_armed_i & ~stack_full_i;
        st_d = st_q;
        if (ack_i) begin
            st_d.req = 1'b0;
        end else if (take) begin
            st_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = st_q.req;

endmodule

// File: rtl/irq_shared_top.sv
module irq_shared_top #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic [N_SRC-1:0] src_en_i,
    input  logic             grp_en_i,
    input  logic             glb_en_i,
    input  logic             stack_full_i,
    input  logic             ack_i,
    input  logic [N_SRC-1:0] src_clr_i,
    input  logic             grp_clr_i,
    output logic [N_SRC-1:0] src_flag_o,
    output logic             grp_flag_o,
    output logic             vec_req_o
);

    logic [N_SRC-1:0] armed;
    logic             any_armed;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        irq_src_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (evt_i[i]),
            .clr_i   (src_clr_i[i]),
            .en_i    (src_en_i[i]),
            .flag_o  (src_flag_o[i]),
            .armed_o (armed[i])
        );
    end

    assign any_armed = |armed;

    irq_grp_flag #(.N_SRC(N_SRC)) u_grp (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .sw_clr_i (grp_clr_i),
        .ack_i    (ack_i),
        .flag_o   (grp_flag_o)
    );

    irq_vec_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .glb_en_i     (glb_en_i),
        .grp_en_i     (grp_en_i),
        .grp_flag_i   (grp_flag_o),
        .any_armed_i  (any_armed),
        .stack_full_i (stack_full_i),
        .ack_i        (ack_i),
        .req_o        (vec_req_o)
    );

endmodule

// File: rtl/irq_shared_chk.sv
module irq_shared_chk #(
    parameter int N_SRC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] evt_i,
    input logic [N_SRC-1:0] src_en_i,
    input logic             grp_en_i,
    input logic             glb_en_i,
    input logic             stack_full_i,
    input logic             ack_i,
    input logic [N_SRC-1:0] src_clr_i,
    input logic             grp_clr_i,
    input logic [N_SRC-1:0] src_flag_o,
    input logic             grp_flag_o,
    input logic             vec_req_o
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_chk
        assert_src_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> src_flag_o[i]);
        assert_src_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (src_flag_o[i] && !src_clr_i[i]) |=> src_flag_o[i]);
        assert_src_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (src_clr_i[i] && !evt_i[i]) |=> !src_flag_o[i]);
    end

    assert_grp_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> grp_flag_o);

    assert_grp_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_clr_i && !(|evt_i)) |=> !grp_flag_o);

    assert_req_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_req_o) |-> $past(glb_en_i && grp_en_i && grp_flag_o && |(src_flag_o & src_en_i)));

    assert_stack_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_req_o) |-> $past(!stack_full_i));

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req_o && !ack_i) |=> vec_req_o);

    assert_ack_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !vec_req_o);

    assert_ack_grp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !(|evt_i)) |=> !grp_flag_o);

endmodule

bind irq_shared_top irq_shared_chk #(.N_SRC(N_SRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt_i),
    .src_en_i     (src_en_i),
    .grp_en_i     (grp_en_i),
    .glb_en_i     (glb_en_i),
    .stack_full_i (stack_full_i),
    .ack_i        (ack_i),
    .src_clr_i    (src_clr_i),
    .grp_clr_i    (grp_clr_i),
    .src_flag_o   (src_flag_o),
    .grp_flag_o   (grp_flag_o),
    .vec_req_o    (vec_req_o)
);

// File: tb/sim_irq_shared_top.sv
`timescale 1ns/1ps
module sim_irq_shared_top;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] evt, src_en, src_clr;
    logic         grp_en, glb_en, stack_full, ack, grp_clr;
    logic [N-1:0] src_flag;
    logic         grp_flag, vec_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    bit [N-1:0] m_src;
    bit         m_grp;
    bit         m_req;

    always #5 clk = ~clk;

    irq_shared_top #(.N_SRC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .src_en_i(src_en),
        .grp_en_i(grp_en), .glb_en_i(glb_en), .stack_full_i(stack_full),
        .ack_i(ack), .src_clr_i(src_clr), .grp_clr_i(grp_clr),
        .src_flag_o(src_flag), .grp_flag_o(grp_flag), .vec_req_o(vec_req)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit         armed;
        bit         take;
        bit [N-1:0] n_src;
        bit         n_grp;
        armed = (m_src & src_en) != 0;
        take  = glb_en && grp_en && m_grp && armed && !stack_full;
        n_src = (m_src & ~src_clr) | evt;
        n_grp = (ack || grp_clr) ? 1'b0 : m_grp;
        if (evt != 0) n_grp = 1'b1;
        if (ack) m_req = 1'b0;
        else if (take) m_req = 1'b1;
        m_src = n_src;
        m_grp = n_grp;
    endtask

    // one clock: update model at the edge, compare at the falling edge
    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            m_src = '0; m_grp = 0; m_req = 0;
        end else begin
            model_step();
        end
        @(negedge clk);
        check("R1 source flags", src_flag, m_src);
        check("R2 group flag", grp_flag, m_grp);
        check("R5 vector request", vec_req, m_req);
    endtask

    task automatic idle_inputs();
        evt = '0; src_clr = '0; grp_clr = 0; ack = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; idle_inputs();
        src_en = '0; grp_en = 0; glb_en = 0; stack_full = 0;
        m_src = '0; m_grp = 0; m_req = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R10 reset state
        check("R10 src after reset", src_flag, 0);
        check("R10 grp after reset", grp_flag, 0);
        check("R10 req after reset", vec_req, 0);

        // R1/R2 flags set with everything disabled, no request
        evt = 4'b0010; tick(); idle_inputs();
        check("R1 flag set while disabled", src_flag, 4'b0010);
        check("R2 group set while disabled", grp_flag, 1);
        repeat (2) tick();
        check("R5 no request while disabled", vec_req, 0);

        // R6 stack full blocks even with all enables
        src_en = '1; grp_en = 1; glb_en = 1; stack_full = 1;
        repeat (3) tick();
        check("R6 blocked by stack full", vec_req, 0);
        stack_full = 0; tick();
        check("R5 request after stack frees", vec_req, 1);

        // R7 hold while enables drop and stack fills
        glb_en = 0; grp_en = 0; src_en = '0; stack_full = 1;
        repeat (3) tick();
        check("R7 request held", vec_req, 1);

        // R8/R9 acknowledge
        ack = 1; tick(); idle_inputs();
        check("R8 request cleared by ack", vec_req, 0);
        check("R8 group cleared by ack", grp_flag, 0);
        check("R9 source flag survives ack", src_flag, 4'b0010);

        // R3 clear vs event same cycle on one source, clear alone on another
        evt = 4'b0100; tick(); idle_inputs();
        src_clr = 4'b0110; evt = 4'b0100; tick(); idle_inputs();
        check("R3 event wins over clear", src_flag[2], 1);
        check("R3 clear alone", src_flag[1], 0);

        // R4 group clear vs event
        grp_clr = 1; tick(); idle_inputs();
        check("R4 group cleared", grp_flag, 0);
        grp_clr = 1; evt = 4'b0001; tick(); idle_inputs();
        check("R4 event wins over group clear", grp_flag, 1);

        // R8 ack with event in same cycle keeps group flag
        stack_full = 0; glb_en = 1; grp_en = 1; src_en = 4'b0001;
        tick();
        check("R5 request from source 0", vec_req, 1);
        ack = 1; evt = 4'b1000; tick(); idle_inputs();
        check("R8 event keeps group flag over ack", grp_flag, 1);
        check("R8 request dropped on ack", vec_req, 0);
        src_clr = '1; grp_clr = 1; tick(); idle_inputs();
        tick();

        // random phase, compared against the model on every clock
        for (int k = 0; k < 400; k++) begin
            evt        = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
            src_clr    = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
            grp_clr    = ($urandom_range(0, 7) == 0);
            src_en     = N'($urandom);
            grp_en     = ($urandom_range(0, 3) != 0);
            glb_en     = ($urandom_range(0, 3) != 0);
            stack_full = ($urandom_range(0, 3) == 0);
            ack        = m_req && ($urandom_range(0, 2) == 0);
            tick();
        end
        idle_inputs();
        tick();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule